// File: doc/BRIEF.md
# I2C Bus Busy Monitor

This block watches an I2C bus passively and tells the local master whether it may begin a transfer. It looks at the already synchronized SCL and SDA levels on every system clock and spots START conditions (SDA falling while SCL stays high) and STOP conditions (SDA rising while SCL stays high), whichever master makes them. Each one is reported as a single-cycle pulse.

After a STOP the bus is not released at once. A bus-free window of `FREE_CYCLES` system clocks must run out first, and a START seen inside that window cancels the release. When the block leaves reset it cannot know whether a transfer is already under way, so it starts in the busy state. From that state it releases the bus either through the normal STOP path or after `IDLE_CYCLES` consecutive samples with both lines high. With a 250 MHz clock the defaults give about 4.7 µs and 4 ms. The block drives nothing onto the bus. All its outputs are plain control levels and pulses, so it has no stream handshake and no back-pressure.

Top module: `i2c_busmon`

## Requirements
- R1: During reset and in the first cycle after reset, `bus_busy_o` is 1 and `start_det_o` and `stop_det_o` are 0.
- R2: `start_det_o` is 1, combinationally, in the cycle whose input sample has SCL=1 and SDA=0 when the previous sample had SCL=1 and SDA=1. It is 0 in every other cycle.
- R3: `stop_det_o` is 1, combinationally, in the cycle whose input sample has SCL=1 and SDA=1 when the previous sample had SCL=1 and SDA=0. It is 0 in every other cycle.
- R4: In the cycle after `start_det_o` is 1, `bus_busy_o` is 1, whatever state the monitor was in.
- R5: If `stop_det_o` is 1 in cycle k while the bus is busy and no START follows, `bus_busy_o` is still 1 in cycle k+FREE_CYCLES and is 0 from cycle k+FREE_CYCLES+1.
- R6: A START during the bus-free countdown cancels it. `bus_busy_o` then stays 1 until a later STOP has run its full countdown.
- R7: Starting from reset, if SCL=1 and SDA=1 are sampled in IDLE_CYCLES consecutive cycles, `bus_busy_o` is 0 in the cycle after the last of those samples and still 1 in the cycle of that sample.
- R8: A sample with SCL=0 or SDA=0 restarts the idle count of R7 from zero.
- R9: Once a START has been seen, idle-high lines alone never release the bus. Only the STOP path of R5 does.
- R10: While the bus is free, SCL and SDA activity that forms no START (SCL toggling with SDA high, SDA changing while SCL is low, SCL rising while SDA is low) keeps `bus_busy_o` at 0 and `start_det_o` at 0.
- R11: A sample in which SCL and SDA change together (both fall or both rise) is neither a START nor a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| bus_busy_o | output | 1 | 1 while the bus must not be claimed |
| start_det_o | output | 1 | One-cycle pulse on a START condition |
| stop_det_o | output | 1 | One-cycle pulse on a STOP condition |

## Verification
The bench builds the monitor with FREE_CYCLES=12 and IDLE_CYCLES=40. With these values the exact release cycle of both the bus-free countdown and the reset idle window can be reached and checked on both sides of the boundary within a few dozen clocks. The default values would need about a million clocks for the idle window. The small windows also leave room to restart the idle count part way through, to cancel a countdown in its middle, and to hold the lines high well past the idle limit after a START.

// File: rtl/i2c_busmon_pkg.sv
package i2c_busmon_pkg;
  typedef enum logic [1:0] {
    MON_UNKNOWN = 2'd0,
    MON_BUSY    = 2'd1,
    MON_DRAIN   = 2'd2,
    MON_FREE    = 2'd3
  } mon_state_e;
endpackage

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  // Previous sample; reset high so that a quiet bus produces no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // SCL must be high in both samples; only SDA may move.
  assign start_o = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o  = scl_q & scl_i & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_hold_timer.sv
module i2c_hold_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end = (cnt == CW'(LIMIT - 1));
  assign done_o = en_i & ~clr_i & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr_i)             cnt <= '0;
    else if (en_i && !at_end)   cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/i2c_busmon.sv
module i2c_busmon
  import i2c_busmon_pkg::*;
#(
  parameter int unsigned FREE_CYCLES = 1175,
  parameter int unsigned IDLE_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic bus_busy_o,
  output logic start_det_o,
  output logic stop_det_o
);
  mon_state_e state, state_nxt;
  logic start_w, stop_w;
  logic idle_done, free_done;
  logic lines_high;

  i2c_cond_detect u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .start_o (start_w),
    .stop_o  (stop_w)
  );

  assign lines_high = scl_i & sda_i;

  // Idle window: only meaningful while the bus state is unknown.
  i2c_hold_timer #(.LIMIT(IDLE_CYCLES)) u_idle_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (~lines_high | (state != MON_UNKNOWN)),
    .en_i   (lines_high),
    .done_o (idle_done)
  );

  // Bus-free window: runs while draining after a STOP.
  i2c_hold_timer #(.LIMIT(FREE_CYCLES)) u_free_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  ((state != MON_DRAIN) | stop_w),
    .en_i   (1'b1),
    .done_o (free_done)
  );

  always_comb begin
    state_nxt = state;
    if (start_w) begin
      state_nxt = MON_BUSY;
    end else if (stop_w && state != MON_FREE) begin
      state_nxt = MON_DRAIN;
    end else begin
      case (state)
        MON_UNKNOWN: if (idle_done) state_nxt = MON_FREE;
        MON_DRAIN:   if (free_done) state_nxt = MON_FREE;
        default:     state_nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= MON_UNKNOWN;
    else        state <= state_nxt;
  end

  assign bus_busy_o  = (state != MON_FREE);
  assign start_det_o = start_w;
  assign stop_det_o  = stop_w;
endmodule

// File: rtl/i2c_busmon_chk.sv
module i2c_busmon_chk #(
  parameter int unsigned FREE_CYCLES = 1175,
  parameter int unsigned IDLE_CYCLES = 1000000
) (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_i,
  input logic bus_busy_o,
  input logic start_det_o,
  input logic stop_det_o
);
  logic        past_ok;
  logic        stop_armed;
  logic [31:0] since_stop;
  logic [31:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok    <= 1'b0;
      stop_armed <= 1'b0;
      since_stop <= '0;
      hi_run     <= '0;
    end else begin
      past_ok <= 1'b1;
      if (stop_det_o) begin
        stop_armed <= 1'b1;
        since_stop <= '0;
      end else if (start_det_o) begin
        stop_armed <= 1'b0;
      end else if (stop_armed && since_stop != 32'hFFFF_FFFF) begin
        since_stop <= since_stop + 32'd1;
      end
      if (scl_i && sda_i) begin
        if (hi_run != 32'hFFFF_FFFF) hi_run <= hi_run + 32'd1;
      end else begin
        hi_run <= '0;
      end
    end
  end

  assert_start_shape_R2: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    start_det_o |-> (scl_i && !sda_i && $past(scl_i) && $past(sda_i)));

  assert_stop_shape_R3: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    stop_det_o |-> (scl_i && sda_i && $past(scl_i) && !$past(sda_i)));

  assert_busy_after_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_det_o |=> bus_busy_o);

  // R5 / R7: a release only after a full free window or a full idle window
  assert_release_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy_o) |-> ((stop_armed && since_stop >= FREE_CYCLES) ||
                           (hi_run >= IDLE_CYCLES)));

  assert_free_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_busy_o && !start_det_o) |=> !bus_busy_o);
endmodule

bind i2c_busmon i2c_busmon_chk #(
  .FREE_CYCLES(FREE_CYCLES),
  .IDLE_CYCLES(IDLE_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_i       (scl_i),
  .sda_i       (sda_i),
  .bus_busy_o  (bus_busy_o),
  .start_det_o (start_det_o),
  .stop_det_o  (stop_det_o)
);

// File: tb/i2c_busmon_tb.sv
module i2c_busmon_tb;
  localparam int unsigned FREE = 12;
  localparam int unsigned IDLE = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b0;
  logic sda = 1'b0;
  logic bus_busy, start_det, stop_det;
  logic obs_bb, obs_st, obs_sp;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  i2c_busmon #(.FREE_CYCLES(FREE), .IDLE_CYCLES(IDLE)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl),
    .sda_i       (sda),
    .bus_busy_o  (bus_busy),
    .start_det_o (start_det),
    .stop_det_o  (stop_det)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive lines mid-cycle, observe outputs before the next edge.
  task automatic tick(input logic s, input logic d);
    @(negedge clk);
    scl = s;
    sda = d;
    #1;
    obs_bb = bus_busy;
    obs_st = start_det;
    obs_sp = stop_det;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    scl = 1'b0;
    sda = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic go_free();
    do_reset();
    repeat (IDLE + 1) tick(1'b1, 1'b1);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 busy after reset", bus_busy, 1'b1);
    check("R1 start pulse idle", start_det, 1'b0);
    check("R1 stop pulse idle", stop_det, 1'b0);
  endtask

  task automatic t_idle_release();
    do_reset();
    for (int i = 1; i <= IDLE + 1; i++) begin
      tick(1'b1, 1'b1);
      if (i == IDLE)     check("R7 busy at last idle sample", obs_bb, 1'b1);
      if (i == IDLE + 1) check("R7 free after idle window", obs_bb, 1'b0);
    end
  endtask

  task automatic t_idle_restart();
    do_reset();
    repeat (30) tick(1'b1, 1'b1);
    tick(1'b0, 1'b1);
    for (int i = 1; i <= IDLE + 1; i++) begin
      tick(1'b1, 1'b1);
      if (i == 15)       check("R8 count restarted", obs_bb, 1'b1);
      if (i == IDLE)     check("R8 busy before restarted window ends", obs_bb, 1'b1);
      if (i == IDLE + 1) check("R8 free after restarted window", obs_bb, 1'b0);
    end
  endtask

  task automatic t_start_stop();
    go_free();
    tick(1'b1, 1'b0);
    check("R2 start pulse", obs_st, 1'b1);
    check("R2 no stop on start", obs_sp, 1'b0);
    check("R4 still free in start cycle", obs_bb, 1'b0);
    tick(1'b0, 1'b0);
    check("R4 busy after start", obs_bb, 1'b1);
    check("R2 start is one cycle", obs_st, 1'b0);
    tick(1'b0, 1'b1);
    tick(1'b1, 1'b1);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b0);
    tick(1'b1, 1'b0);
    check("R2 no start when SCL rises", obs_st, 1'b0);
    tick(1'b1, 1'b1);
    check("R3 stop pulse", obs_sp, 1'b1);
    check("R5 busy in stop cycle", obs_bb, 1'b1);
    for (int i = 1; i <= FREE + 1; i++) begin
      tick(1'b1, 1'b1);
      if (i == 1)        check("R3 stop is one cycle", obs_sp, 1'b0);
      if (i == FREE)     check("R5 busy at end of free window", obs_bb, 1'b1);
      if (i == FREE + 1) check("R5 free after free window", obs_bb, 1'b0);
    end
  endtask

  task automatic t_cancel();
    go_free();
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b1);
    check("R3 stop before cancel", obs_sp, 1'b1);
    repeat (FREE / 2) tick(1'b1, 1'b1);
    tick(1'b1, 1'b0);
    check("R6 restart seen in countdown", obs_st, 1'b1);
    check("R6 busy during countdown", obs_bb, 1'b1);
    repeat (FREE + 4) tick(1'b1, 1'b0);
    check("R6 countdown cancelled", obs_bb, 1'b1);
  endtask

  task automatic t_no_idle_after_start();
    do_reset();
    repeat (5) tick(1'b1, 1'b1);
    tick(1'b1, 1'b0);
    check("R9 start from unknown", obs_st, 1'b1);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b1);
    repeat (IDLE + 5) tick(1'b1, 1'b1);
    check("R9 idle lines do not release", obs_bb, 1'b1);
  endtask

  task automatic t_free_toggle();
    logic any_st = 1'b0;
    logic any_bb = 1'b0;
    go_free();
    tick(1'b0, 1'b1); any_st |= obs_st; any_bb |= obs_bb;
    tick(1'b1, 1'b1); any_st |= obs_st; any_bb |= obs_bb;
    tick(1'b0, 1'b1); any_st |= obs_st; any_bb |= obs_bb;
    tick(1'b0, 1'b0); any_st |= obs_st; any_bb |= obs_bb;
    tick(1'b1, 1'b0); any_st |= obs_st; any_bb |= obs_bb;
    tick(1'b0, 1'b0); any_st |= obs_st; any_bb |= obs_bb;
    tick(1'b0, 1'b1); any_st |= obs_st; any_bb |= obs_bb;
    tick(1'b1, 1'b1); any_st |= obs_st; any_bb |= obs_bb;
    tick(1'b1, 1'b1); any_st |= obs_st; any_bb |= obs_bb;
    check("R10 no start from non-START activity", any_st, 1'b0);
    check("R10 stays free", any_bb, 1'b0);
  endtask

  task automatic t_simultaneous();
    go_free();
    tick(1'b0, 1'b0);
    check("R11 joint fall is not START", obs_st, 1'b0);
    tick(1'b0, 1'b0);
    check("R11 bus still free after joint fall", obs_bb, 1'b0);
    tick(1'b1, 1'b1);
    check("R11 joint rise is not STOP", obs_sp, 1'b0);
  endtask

  initial begin
    t_reset();
    t_idle_release();
    t_idle_restart();
    t_start_stop();
    t_cancel();
    t_no_idle_after_start();
    t_free_toggle();
    t_simultaneous();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule